// File: doc/BRIEF.md
# Descriptor Ring Doorbell Poller

This block pairs a one-bit doorbell command register with a small sequencer that walks a circular ring of buffer descriptors for a DMA-driven network controller. Software writes the doorbell to say that new descriptors are in the ring. The value written does not matter: the write alone raises an internal active flag. While that flag is set and the global controller enable is on, the sequencer reads one descriptor at a time through a request/valid memory read port. It checks the ownership bit of each descriptor. It passes each owned descriptor to a downstream consumer over a valid/ready interface.

When the sequencer fetches a descriptor whose ownership bit is clear, it drops the active flag and stops until software rings the doorbell again. Turning the global enable off clears the flag. A soft reset also clears the flag and rewinds the ring pointer to the first descriptor. The ring pointer moves on only when the consumer accepts a descriptor. It returns to the ring base after the last slot, or earlier when a descriptor carries its own wrap marker.

Top module: `ring_doorbell_poller`

## Requirements
- R1: A write to register offset 0x14 sets the active flag from the next cycle, whatever the write data. A write to any other offset leaves the flag unchanged.
- R2: A read at offset 0x14 returns the active flag in bit 24, with every other bit zero. A read at any other offset returns zero.
- R3: While reset is asserted and just after it is released, the active flag is 0, no memory request or descriptor is presented, and the ring index is 0.
- R4: A memory request is raised only in the cycle after one in which the active flag and the enable were both set and soft reset was low. With the enable set but the flag clear, no request is issued.
- R5: A memory request stays asserted, with a stable address, until read data is returned. The address is RING_BASE + index * DESC_STRIDE.
- R6: When the returned descriptor has bit 31 (ownership) clear, the active flag is 0 from the next cycle, polling stops, and the ring index is unchanged.
- R7: A doorbell write in the same cycle as such a self-clear keeps the flag set. The same ring index is then fetched again in the following cycle.
- R8: An owned descriptor is presented with valid and held stable until the consumer signals ready. The ring index advances by one only on that acceptance.
- R9: On acceptance, the index returns to 0 if the descriptor has bit 29 (wrap) set or the index is the last slot.
- R10: A 1-to-0 transition of the enable clears the active flag from the next cycle. Any fetch or presentation in flight is dropped, and the ring index is kept.
- R11: Soft reset clears the active flag, even against a doorbell write in the same cycle, and resets the ring index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data (value ignored) |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| eth_en_i | input | 1 | Global controller enable |
| soft_rst_i | input | 1 | Soft reset control |
| active_o | output | 1 | Active flag |
| mem_req_o | output | 1 | Descriptor read request |
| mem_addr_o | output | ADDR_W | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DESC_W | Read data (descriptor word) |
| desc_valid_o | output | 1 | Owned descriptor available |
| desc_data_o | output | DESC_W | Descriptor word |
| desc_idx_o | output | IDX_W | Current ring index |
| desc_ready_i | input | 1 | Consumer accepts descriptor |

## Verification
The bench builds the block with a four-slot ring at base 0x100 and an 8-byte stride, so the power-of-two address path is used. The small ring means that both the last-slot wrap and the descriptor wrap bit come up within a few dozen cycles. The bench varies the memory read latency from zero to two wait cycles. A zero-latency read is the only way to land a doorbell write in the exact cycle of a self-clear. The longer latency, combined with consumer back-pressure, exercises the hold conditions on the request and on the presented descriptor.

// File: rtl/ring_poll_pkg.sv
package ring_poll_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_PRESENT = 2'd2
  } poll_st_e;

  localparam int          DB_ACTIVE_BIT = 24;
  localparam int unsigned DB_OFFSET     = 'h14;
endpackage

// File: rtl/doorbell_flag.sv
module doorbell_flag
  import ring_poll_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              eth_en_i,
  input  logic              soft_rst_i,
  input  logic              self_clr_i,
  output logic              active_o,
  output logic [31:0]       reg_rdata_o
);
  logic hit, db_wr, en_q, en_fall, active_q;

  assign hit     = (reg_addr_i == REG_AW'(DB_OFFSET));
  assign db_wr   = reg_wr_i & hit;
  assign en_fall = en_q & ~eth_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      en_q <= eth_en_i;
      if (soft_rst_i || en_fall) active_q <= 1'b0;
      else if (db_wr)            active_q <= 1'b1;  // write beats self-clear
      else if (self_clr_i)       active_q <= 1'b0;
    end
  end

  assign active_o = active_q;

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[DB_ACTIVE_BIT] = hit & active_q;
  end

  // R1
  a_r1_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_wr && !soft_rst_i && !en_fall) |=> active_o);
  // R2
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~(32'h1 << DB_ACTIVE_BIT)) == 32'h0);
  // R6
  a_r6_self_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (self_clr_i && !db_wr) |=> !active_o);
  // R10
  a_r10_en_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !eth_en_i) |=> !active_o);
  // R11
  a_r11_soft_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !active_o);
endmodule

// File: rtl/ring_ptr.sv
module ring_ptr #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic             wrap_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (clr_i) idx_q <= '0;
    else if (adv_i) idx_q <= (wrap_i || idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  // R8
  a_r8_idx_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(adv_i || clr_i) |=> $stable(idx_o));
  // R9
  a_r9_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_o <= LAST);
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import ring_poll_pkg::*;
#(
  parameter int DESC_W    = 32,
  parameter int READY_BIT = 31,
  parameter int WRAP_BIT  = 29
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  input  logic              desc_ready_i,
  output logic              mem_req_o,
  output logic              desc_valid_o,
  output logic [DESC_W-1:0] desc_data_o,
  output logic              self_clr_o,
  output logic              adv_o,
  output logic              wrap_o
);
  poll_st_e st_q, st_d;
  logic [DESC_W-1:0] data_q;
  logic owned, take;

  assign owned = mem_rdata_i[READY_BIT];
  assign take  = (st_q == ST_FETCH) & run_i & mem_rvalid_i & owned;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (run_i) st_d = ST_FETCH;
      ST_FETCH:   if (!run_i) st_d = ST_IDLE;
                  else if (mem_rvalid_i) st_d = owned ? ST_PRESENT : ST_IDLE;
      ST_PRESENT: if (!run_i) st_d = ST_IDLE;
                  else if (desc_ready_i) st_d = ST_FETCH;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) data_q <= mem_rdata_i;
    end
  end

  assign mem_req_o    = (st_q == ST_FETCH);
  assign desc_valid_o = (st_q == ST_PRESENT);
  assign desc_data_o  = data_q;
  assign self_clr_o   = (st_q == ST_FETCH) & run_i & mem_rvalid_i & ~owned;
  assign adv_o        = (st_q == ST_PRESENT) & run_i & desc_ready_i;
  assign wrap_o       = data_q[WRAP_BIT];

  // R4
  a_r4_req_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(run_i));
  // R5
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i && run_i) |=> mem_req_o);
  // R6
  a_r6_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_clr_o |=> (!mem_req_o && !desc_valid_o));
  // R8
  a_r8_desc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_valid_o && !desc_ready_i && run_i) |=> (desc_valid_o && $stable(desc_data_o)));
endmodule

// File: rtl/ring_doorbell_poller.sv
module ring_doorbell_poller #(
  parameter int          RING_DEPTH  = 8,
  parameter int          ADDR_W      = 16,
  parameter int          DESC_W      = 32,
  parameter int unsigned RING_BASE   = 'h100,
  parameter int unsigned DESC_STRIDE = 8,
  parameter int          READY_BIT   = 31,
  parameter int          WRAP_BIT    = 29,
  parameter int          REG_AW      = 8,
  localparam int         IDX_W       = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              eth_en_i,
  input  logic              soft_rst_i,
  output logic              active_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DESC_W-1:0] mem_rdata_i,
  output logic              desc_valid_o,
  output logic [DESC_W-1:0] desc_data_o,
  output logic [IDX_W-1:0]  desc_idx_o,
  input  logic              desc_ready_i
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(RING_BASE);

  logic [31:0] wdata_unused;
  logic active, run, self_clr, adv, wrap;
  logic [IDX_W-1:0] idx;

  assign wdata_unused = reg_wdata_i;  // doorbell ignores the data value
  assign run = active & eth_en_i & ~soft_rst_i;

  doorbell_flag #(.REG_AW(REG_AW)) i_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .eth_en_i   (eth_en_i),
    .soft_rst_i (soft_rst_i),
    .self_clr_i (self_clr),
    .active_o   (active),
    .reg_rdata_o(reg_rdata_o)
  );

  poll_fsm #(.DESC_W(DESC_W), .READY_BIT(READY_BIT), .WRAP_BIT(WRAP_BIT)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .desc_ready_i(desc_ready_i),
    .mem_req_o   (mem_req_o),
    .desc_valid_o(desc_valid_o),
    .desc_data_o (desc_data_o),
    .self_clr_o  (self_clr),
    .adv_o       (adv),
    .wrap_o      (wrap)
  );

  ring_ptr #(.DEPTH(RING_DEPTH), .IDX_W(IDX_W)) i_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (soft_rst_i),
    .adv_i (adv),
    .wrap_i(wrap),
    .idx_o (idx)
  );

  generate
    if (DESC_STRIDE > 0 && (DESC_STRIDE & (DESC_STRIDE - 1)) == 0) begin : g_shift
      assign mem_addr_o = BASE_A + (ADDR_W'(idx) << $clog2(DESC_STRIDE));
    end else begin : g_mul
      localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(DESC_STRIDE);
      assign mem_addr_o = BASE_A + ADDR_W'(idx) * STRIDE_A;
    end
  endgenerate

  assign active_o   = active;
  assign desc_idx_o = idx;

  // R5
  a_r5_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rvalid_i && run) |=> $stable(mem_addr_o));
  // R11
  a_r11_idx_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (desc_idx_o == '0));
endmodule

// File: tb/test_ring_doorbell_poller.sv
module test_ring_doorbell_poller;
  localparam int DEPTH  = 4;
  localparam int IDX_W  = 2;
  localparam int BASE   = 'h100;
  localparam int STRIDE = 8;
  localparam int RDY    = 31;
  localparam int WRP    = 29;
  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] WRB = 32'h2000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, reg_wr_i, eth_en_i, soft_rst_i, mem_rvalid_i, desc_ready_i;
  logic [7:0] reg_addr_i;
  logic [31:0] reg_wdata_i, reg_rdata_o, mem_rdata_i, desc_data_o;
  logic active_o, mem_req_o, desc_valid_o;
  logic [15:0] mem_addr_o;
  logic [IDX_W-1:0] desc_idx_o;

  ring_doorbell_poller #(
    .RING_DEPTH(DEPTH), .ADDR_W(16), .DESC_W(32), .RING_BASE(BASE),
    .DESC_STRIDE(STRIDE), .READY_BIT(RDY), .WRAP_BIT(WRP), .REG_AW(8)
  ) i_ring_doorbell_poller (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .eth_en_i(eth_en_i),
    .soft_rst_i(soft_rst_i), .active_o(active_o), .mem_req_o(mem_req_o),
    .mem_addr_o(mem_addr_o), .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .desc_valid_o(desc_valid_o), .desc_data_o(desc_data_o), .desc_idx_o(desc_idx_o),
    .desc_ready_i(desc_ready_i)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // descriptor memory with programmable latency
  logic [31:0] ring [DEPTH];
  int mem_lat = 0;
  int lat_cnt = 0;
  always @(posedge clk)
    if (mem_req_o && !mem_rvalid_i) lat_cnt <= lat_cnt + 1;
    else lat_cnt <= 0;
  always @(negedge clk) begin : mem_drv
    int ai;
    #1;
    ai = (int'(mem_addr_o) - BASE) / STRIDE;
    if (ai < 0 || ai >= DEPTH) ai = 0;
    mem_rvalid_i = mem_req_o && (lat_cnt >= mem_lat);
    mem_rdata_i  = ring[ai];
  end

  // behavioural reference model
  int m_st, m_idx;
  bit m_act, m_enq;
  logic [31:0] m_data;
  always @(posedge clk or negedge rst_ni) begin : model
    bit run, wr, sc, acc;
    if (!rst_ni) begin
      m_st = 0; m_idx = 0; m_act = 0; m_enq = 0; m_data = 0;
    end else begin
      run = m_act && eth_en_i && !soft_rst_i;
      wr  = reg_wr_i && reg_addr_i == 8'h14;
      sc  = (m_st == 1) && run && mem_rvalid_i && !mem_rdata_i[RDY];
      acc = (m_st == 2) && run && desc_ready_i;
      if (soft_rst_i) m_idx = 0;
      else if (acc) m_idx = (m_data[WRP] || m_idx == DEPTH - 1) ? 0 : m_idx + 1;
      case (m_st)
        0: if (run) m_st = 1;
        1: if (!run) m_st = 0;
           else if (mem_rvalid_i) begin
             if (mem_rdata_i[RDY]) begin m_data = mem_rdata_i; m_st = 2; end
             else m_st = 0;
           end
        default: if (!run) m_st = 0; else if (desc_ready_i) m_st = 1;
      endcase
      if (soft_rst_i) m_act = 0;
      else if (m_enq && !eth_en_i) m_act = 0;
      else if (wr) m_act = 1;
      else if (sc) m_act = 0;
      m_enq = eth_en_i;
    end
  end

  always @(negedge clk) begin
    if (rst_ni === 1'b1 && !done) begin
      chk("R1 R6 R10 R11 active", {31'd0, active_o}, {31'd0, m_act});
      chk("R4 R5 mem_req", {31'd0, mem_req_o}, {31'd0, m_st == 1});
      if (m_st == 1) chk("R5 mem_addr", {16'd0, mem_addr_o}, BASE + m_idx * STRIDE);
      chk("R8 desc_valid", {31'd0, desc_valid_o}, {31'd0, m_st == 2});
      if (m_st == 2) chk("R8 desc_data", desc_data_o, m_data);
      chk("R8 R9 desc_idx", {30'd0, desc_idx_o}, m_idx);
      chk("R2 rdata", reg_rdata_o, (reg_addr_i == 8'h14 && m_act) ? 32'h0100_0000 : 32'h0);
    end
  end

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic db_write(input logic [7:0] a, input logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    step();
    reg_wr_i = 1'b0; reg_wdata_i = 32'h0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (active_o && n < 2000) begin step(); n++; end
    if (n >= 2000) chk("R6 wait for stop", 32'd1, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k, n;
    bit saw_wrap;
    logic [IDX_W-1:0] prev, held;
    rst_ni = 1'b0; reg_wr_i = 0; reg_addr_i = 8'h14; reg_wdata_i = 0;
    eth_en_i = 0; soft_rst_i = 0; desc_ready_i = 0;
    mem_rvalid_i = 0; mem_rdata_i = 0;
    ring[0] = OWN | 32'h11; ring[1] = OWN | 32'h22; ring[2] = 32'h33; ring[3] = OWN | 32'h44;
    repeat (3) @(negedge clk);
    #2;
    chk("R3 active in reset", {31'd0, active_o}, 32'd0);
    chk("R3 req in reset", {31'd0, mem_req_o}, 32'd0);
    chk("R3 valid in reset", {31'd0, desc_valid_o}, 32'd0);
    chk("R3 idx in reset", {30'd0, desc_idx_o}, 32'd0);
    chk("R3 rdata in reset", reg_rdata_o, 32'h0);
    rst_ni = 1'b1;
    step();
    chk("R3 idle after release", {31'd0, mem_req_o}, 32'd0);

    // doorbell with zero data, enable still low
    db_write(8'h14, 32'h0);
    chk("R1 zero data sets flag", {31'd0, active_o}, 32'd1);
    repeat (4) step();
    chk("R4 no request without enable", {31'd0, mem_req_o}, 32'd0);

    // poll 0,1 then stop on not-owned slot 2
    desc_ready_i = 1'b1;
    eth_en_i = 1'b1;
    wait_idle();
    chk("R6 index held at not-owned slot", {30'd0, desc_idx_o}, 32'd2);
    chk("R6 no request after stop", {31'd0, mem_req_o}, 32'd0);

    // write at another offset is ignored
    db_write(8'h10, 32'hffff_ffff);
    repeat (3) step();
    chk("R1 other offset ignored", {31'd0, active_o}, 32'd0);
    chk("R1 other offset no poll", {31'd0, mem_req_o}, 32'd0);

    // wrap bit on slot 2, slot 0 not owned
    ring[2] = OWN | WRB | 32'h33; ring[0] = 32'h0;
    db_write(8'h14, 32'hffff_ffff);
    chk("R1 all-ones data sets flag", {31'd0, active_o}, 32'd1);
    chk("R2 flag at bit 24", reg_rdata_o, 32'h0100_0000);
    reg_addr_i = 8'h10;
    #1;
    chk("R2 other offset reads zero", reg_rdata_o, 32'h0);
    wait_idle();
    chk("R9 wrap bit returns to base", {30'd0, desc_idx_o}, 32'd0);

    // latency and back-pressure, all slots owned
    ring[0] = OWN | 32'h55; ring[2] = OWN | 32'h66;
    mem_lat = 2;
    db_write(8'h14, 32'h1234_5678);
    saw_wrap = 0;
    prev = desc_idx_o;
    for (int i = 0; i < 90; i++) begin
      desc_ready_i = (i % 3 == 0);
      step();
      if (prev == 2'd3 && desc_idx_o == 2'd0) saw_wrap = 1;
      prev = desc_idx_o;
    end
    chk("R9 last slot wraps", {31'd0, saw_wrap}, 32'd1);

    // enable fall while presenting
    desc_ready_i = 1'b0;
    n = 0;
    while (!desc_valid_o && n < 100) begin step(); n++; end
    chk("R8 descriptor presented", {31'd0, desc_valid_o}, 32'd1);
    held = desc_idx_o;
    eth_en_i = 1'b0;
    step();
    chk("R10 flag cleared on enable fall", {31'd0, active_o}, 32'd0);
    chk("R10 presentation dropped", {31'd0, desc_valid_o}, 32'd0);
    repeat (2) step();
    chk("R10 index kept", {30'd0, desc_idx_o}, {30'd0, held});
    eth_en_i = 1'b1;
    repeat (4) step();
    chk("R4 no request with flag clear", {31'd0, mem_req_o}, 32'd0);

    // doorbell in the same cycle as self-clear
    mem_lat = 0;
    desc_ready_i = 1'b1;
    k = int'(desc_idx_o);
    ring[k] = 32'h0;
    db_write(8'h14, 32'h0);
    n = 0;
    while (!(mem_req_o && mem_rvalid_i) && n < 100) begin step(); n++; end
    reg_wr_i = 1'b1; reg_addr_i = 8'h14;
    step();
    reg_wr_i = 1'b0;
    chk("R7 write wins over self-clear", {31'd0, active_o}, 32'd1);
    chk("R7 index unchanged", {30'd0, desc_idx_o}, k);
    step();
    chk("R7 refetch issued", {31'd0, mem_req_o}, 32'd1);
    chk("R7 refetch same slot", {16'd0, mem_addr_o}, BASE + k * STRIDE);
    wait_idle();
    ring[k] = OWN | 32'h77;

    // soft reset against a doorbell write
    db_write(8'h14, 32'h0);
    n = 0;
    while (desc_idx_o == '0 && n < 100) begin step(); n++; end
    reg_wr_i = 1'b1; reg_addr_i = 8'h14; soft_rst_i = 1'b1;
    step();
    reg_wr_i = 1'b0; soft_rst_i = 1'b0;
    chk("R11 soft reset clears flag", {31'd0, active_o}, 32'd0);
    chk("R11 soft reset rewinds index", {30'd0, desc_idx_o}, 32'd0);
    chk("R11 no request after soft reset", {31'd0, mem_req_o}, 32'd0);
    repeat (3) step();
    chk("R11 stays stopped", {31'd0, mem_req_o | desc_valid_o}, 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule